// File: doc/BRIEF.md
# Serial CRC-5 Remainder Engine

This block computes a 5-bit cyclic redundancy remainder over a serial bit stream, using the generator x^5 + x^4 + x^2 + 1 (binary 110101). Bits arrive most significant first, one per cycle, on a data input qualified by a valid strobe. A separate flag marks the final bit. The engine works in the padded long-division style. After it takes the final bit, it shifts five zero bits through the remainder register by itself on the next five cycles. It then raises a one-cycle completion pulse, and the remainder at its output is the CRC.

A mode input is sampled on the start pulse. In generate mode the remainder is the CRC to append to the message. In check mode the stream is a whole codeword, meaning the message followed by its five CRC bits. The engine then reports at completion whether the final remainder is zero. A caller pulses start, streams its bits, waits for the completion pulse, and reads the result.

Top module: `crc5_serial_engine`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, crc_out is 00000 and done, check_ok and busy are all 0.
- R2: A start pulse sets crc_out to 00000 on the next cycle. The mode input is latched on that same cycle.
- R3: For each accepted bit, the engine notes the old MSB and shifts the register left, loading the new bit into bit 0. If the noted MSB was 1, the engine XORs the result with 10101. After a cycle that accepts a bit, crc_out equals the remainder of the bits accepted so far, with no padding applied.
- R4: The cycle that accepts a bit with bit_last high is followed by exactly five cycles with busy high. In each of them one zero bit is processed. done is then high for exactly one cycle, aligned with the first cycle in which busy is low, and crc_out holds the final remainder.
- R5: bit_valid and bit_in have no effect while busy is high. The final remainder is the same as it would be if nothing had been driven during those cycles.
- R6: The 10-bit message 1010001101 produces the CRC 01110.
- R7: In check mode (check_mode = 1 at start), check_ok is high together with done only when the final remainder is 00000. The codeword 101000110101110 produces check_ok = 1.
- R8: In generate mode (check_mode = 0 at start), check_ok stays 0, including during the done cycle. check_ok is never high without done.
- R9: When start, bit_valid and busy are all low, crc_out does not change. In particular, the result stays readable after done.
- R10: When start and bit_valid are high in the same cycle, start takes priority. The bit is dropped and crc_out becomes 00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears the remainder and latches the mode |
| check_mode | input | 1 | 1 = check a codeword, 0 = generate a CRC; sampled on start |
| bit_valid | input | 1 | bit_in carries a stream bit this cycle |
| bit_in | input | 1 | Serial data, most significant bit first |
| bit_last | input | 1 | This valid bit is the final one of the stream |
| busy | output | 1 | Zero-padding in progress; input ignored |
| crc_out | output | 5 | Current remainder; the CRC once done pulses |
| done | output | 1 | One-cycle pulse when the remainder is final |
| check_ok | output | 1 | In check mode, high with done when the remainder is zero |

## Verification
The assertions assume that bit_last is only meaningful together with bit_valid. They also assume that a caller does not pulse start during padding, although the design does tolerate it. The stimulus keeps to both assumptions. Each stream begins with a lone start pulse, bits are driven only between that pulse and the one with bit_last, and the bench waits for done before the next start. Driving bits during busy is done on purpose and only in the R5 test. The R10 test uses a start and a valid bit in the same cycle while the engine is otherwise idle.

// File: rtl/crc5_pkg.sv
package crc5_pkg;

    localparam int CRC_W = 5;
    localparam logic [CRC_W-1:0] FB_MASK = 5'b10101;
    localparam int PAD_N = CRC_W;
    localparam int CNT_W = $clog2(PAD_N + 1);

    typedef logic [CRC_W-1:0] rem_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_PAD  = 1'b1
    } phase_e;

    typedef struct packed {
        logic done;
        logic ok;
    } verdict_t;

    function automatic rem_t div_step(input rem_t cur, input logic din);
        rem_t sh;
        sh = {cur[CRC_W-2:0], din};
        return cur[CRC_W-1] ? (sh ^ FB_MASK) : sh;
    endfunction

endpackage

// File: rtl/crc5_div_stage.sv
module crc5_div_stage
    import crc5_pkg::*;
(
    input  rem_t cur,
    input  logic din,
    output rem_t nxt
);
    logic fb;
    assign fb = cur[CRC_W-1];

    genvar i;
    generate
        for (i = 0; i < CRC_W; i++) begin : g_tap
            if (i == 0) begin : g_lsb
                assign nxt[i] = din ^ (fb & FB_MASK[i]);
            end else begin : g_upper
                assign nxt[i] = cur[i-1] ^ (fb & FB_MASK[i]);
            end
        end
    endgenerate

    always_comb begin
        assert (nxt == div_step(cur, din) || $isunknown({cur, din}))
            else $error("div stage mismatch");
    end
endmodule

// File: rtl/crc5_pad_ctrl.sv
module crc5_pad_ctrl
    import crc5_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic launch,
    output logic pad_active,
    output logic pad_final
);
    phase_e phase_q;
    cnt_t   cnt_q;

    assign pad_active = (phase_q == PH_PAD);
    assign pad_final  = pad_active && (cnt_q == cnt_t'(PAD_N - 1));

    always_ff @(posedge clk) begin
        if (rst || start) begin
            phase_q <= PH_LOAD;
            cnt_q   <= '0;
        end else if (phase_q == PH_LOAD) begin
            if (launch) begin
                phase_q <= PH_PAD;
                cnt_q   <= '0;
            end
        end else begin
            if (pad_final) begin
                phase_q <= PH_LOAD;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4
    pad_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < cnt_t'(PAD_N));

    // R4
    pad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_active && !pad_final && !start) |=> pad_active);

    // R4
    pad_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_final && !start) |=> !pad_active);
endmodule

// File: rtl/crc5_status.sv
module crc5_status
    import crc5_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic check_mode,
    input  logic pad_final,
    input  logic busy,
    input  rem_t final_rem,
    output logic done,
    output logic check_ok
);
    logic     mode_q;
    verdict_t v_q;
    verdict_t v_d;

    always_comb begin
        v_d.done = pad_final && !start;
        v_d.ok   = pad_final && !start && mode_q && (final_rem == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            v_q    <= '0;
        end else begin
            if (start) mode_q <= check_mode;
            v_q <= v_d;
        end
    end

    assign done     = v_q.done;
    assign check_ok = v_q.ok;

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    done_after_pad_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R8
    ok_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        check_ok |-> done);

    // R8
    gen_mode_low_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q) |-> !check_ok);
endmodule

// File: rtl/crc5_serial_engine.sv
module crc5_serial_engine
    import crc5_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       check_mode,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic       bit_last,
    output logic       busy,
    output logic [4:0] crc_out,
    output logic       done,
    output logic       check_ok
);
    rem_t rem_q;
    rem_t rem_nxt;
    logic pad_active;
    logic pad_final;
    logic in_fire;
    logic stage_din;

    assign in_fire   = bit_valid && !pad_active && !start;
    assign stage_din = pad_active ? 1'b0 : bit_in;

    crc5_div_stage u_stage (
        .cur (rem_q),
        .din (stage_din),
        .nxt (rem_nxt)
    );

    crc5_pad_ctrl u_pad (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .launch     (in_fire && bit_last),
        .pad_active (pad_active),
        .pad_final  (pad_final)
    );

    always_ff @(posedge clk) begin
        if (rst || start) begin
            rem_q <= '0;
        end else if (pad_active || in_fire) begin
            rem_q <= rem_nxt;
        end
    end

    crc5_status u_status (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .check_mode (check_mode),
        .pad_final  (pad_final),
        .busy       (pad_active),
        .final_rem  (rem_nxt),
        .done       (done),
        .check_ok   (check_ok)
    );

    assign busy    = pad_active;
    assign crc_out = rem_q;

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && !bit_valid && !busy) |=> $stable(crc_out));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (crc_out == '0 && !busy));

    // R3
    msb_zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (in_fire && !crc_out[CRC_W-1]) |=> (crc_out == {$past(crc_out[CRC_W-2:0]), $past(bit_in)}));
endmodule

// File: tb/crc5_serial_engine_test.sv
module crc5_serial_engine_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       start, check_mode, bit_valid, bit_in, bit_last;
    logic       busy, done, check_ok;
    logic [4:0] crc_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic wd_hit = 1'b0;

    always #5 clk = ~clk;

    crc5_serial_engine uut (
        .clk(clk), .rst(rst), .start(start), .check_mode(check_mode),
        .bit_valid(bit_valid), .bit_in(bit_in), .bit_last(bit_last),
        .busy(busy), .crc_out(crc_out), .done(done), .check_ok(check_ok)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !wd_hit) begin
            wd_hit <= 1'b1;
            fails  <= fails + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
            $finish;
        end
    end

    // remainder of the first len bits of seq (seq[len-1] first), then pad zeros
    function automatic logic [4:0] ref_rem(input logic [63:0] seq, input int len, input int pad);
        logic [4:0] r = 5'b0;
        logic msb;
        for (int i = len - 1; i >= -pad; i--) begin
            msb = r[4];
            r = {r[3:0], (i >= 0) ? seq[i] : 1'b0};
            if (msb) r = r ^ 5'b10101;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start = 0; check_mode = 0; bit_valid = 0; bit_in = 0; bit_last = 0;
    endtask

    task automatic do_start(input logic mode);
        @(negedge clk);
        start = 1; check_mode = mode; bit_valid = 0; bit_last = 0;
        @(negedge clk);
        idle_inputs();
    endtask

    // streams bits; optionally checks crc_out after each bit (R3); optionally drives junk during busy (R5)
    task automatic stream(input logic [63:0] seq, input int len, input logic step_chk, input logic junk);
        for (int i = len - 1; i >= 0; i--) begin
            bit_valid = 1; bit_in = seq[i]; bit_last = (i == 0);
            @(negedge clk);
            idle_inputs();
            if (step_chk) check("R3 prefix remainder", crc_out, ref_rem(seq >> i, len - i, 0));
        end
        if (junk) begin
            bit_valid = 1; bit_in = 1; bit_last = 1;
        end
    endtask

    // after stream: expects exactly 5 busy cycles then done
    task automatic wait_done(input string req, output logic [4:0] res, output logic ok);
        int busy_n = 0;
        while (busy) begin
            busy_n++;
            if (busy_n < 5) check({req, " busy no done"}, done, 0);
            @(negedge clk);
        end
        idle_inputs();
        check({req, " R4 busy length"}, busy_n, 5);
        check({req, " R4 done pulse"}, done, 1);
        res = crc_out;
        ok  = check_ok;
        @(negedge clk);
        check({req, " R4 done one cycle"}, done, 0);
    endtask

    initial begin
        logic [4:0] res;
        logic ok;
        logic [63:0] msg;
        int len;
        logic [4:0] exp;
        void'($urandom(32'd7741));

        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        check("R1 reset crc", crc_out, 0);
        check("R1 reset flags", {done, check_ok, busy}, 0);
        rst = 0;
        @(negedge clk);
        check("R1 after reset", {crc_out, done, check_ok, busy}, 0);

        // R6 directed message with per-bit R3 checks
        do_start(0);
        check("R2 start clears", crc_out, 0);
        stream(64'b1010001101, 10, 1, 0);
        wait_done("R6", res, ok);
        check("R6 crc of 1010001101", res, 5'b01110);
        check("R8 gen mode check_ok low", ok, 0);
        check("R9 result held", crc_out, 5'b01110);
        repeat (3) @(negedge clk);
        check("R9 result held later", crc_out, 5'b01110);

        // R7 codeword check
        do_start(1);
        stream(64'b101000110101110, 15, 0, 0);
        wait_done("R7", res, ok);
        check("R7 codeword remainder", res, 0);
        check("R7 codeword ok", ok, 1);

        // R7 corrupted codeword
        do_start(1);
        stream(64'b101000110101111, 15, 0, 0);
        wait_done("R7 bad", res, ok);
        check("R7 bad codeword flagged", ok, 0);
        check("R7 bad remainder", res, ref_rem(64'b101000110101111, 15, 5));

        // R5 junk during busy
        do_start(0);
        stream(64'b1010001101, 10, 0, 1);
        wait_done("R5", res, ok);
        check("R5 input ignored while busy", res, 5'b01110);

        // R10 start beats valid
        do_start(0);
        stream(64'b111, 3, 0, 0);
        wait_done("R10 pre", res, ok);
        @(negedge clk);
        start = 1; bit_valid = 1; bit_in = 1; bit_last = 0;
        @(negedge clk);
        idle_inputs();
        check("R10 start priority", {crc_out, busy}, 0);

        // single-bit boundary message
        do_start(0);
        stream(64'b1, 1, 1, 0);
        wait_done("R4 1-bit", res, ok);
        check("R6 1-bit crc", res, 5'b10101);

        // random messages 1..32 bits, generate then check
        for (int k = 0; k < 40; k++) begin
            len = 1 + ($urandom % 32);
            msg = {32'b0, $urandom} & ((64'd1 << len) - 1);
            exp = ref_rem(msg, len, 5);
            do_start(0);
            stream(msg, len, (k < 4), 0);
            wait_done("rand gen", res, ok);
            check("R6 random crc", res, exp);
            check("R8 random gen ok low", ok, 0);
            do_start(1);
            stream((msg << 5) | {59'b0, exp}, len + 5, 0, 0);
            wait_done("rand chk", res, ok);
            check("R7 random codeword remainder", res, 0);
            check("R7 random codeword ok", ok, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule